// File: doc/BRIEF.md
# Configuration Command Controller

This block is a small register-mapped command port for a board controller. Software sees three 32-bit registers: a data word, a control word and a two-bit status word. A write to the control word is a complete command. In the same clock edge the block stores a cleaned copy of the word, marks the command as done and decodes it. Two command words are recognised, one that asks the system to power down and one that asks it to restart. Each raises its own request line for exactly one cycle. Any other word leaves both lines low and flags an error in the status.

The three registers exist only when the board identity strap equals the enabled identity, which is 0x190 by default. With any other identity, an access to one of the three offsets is reported on the access-error line. A read then returns zero and a write changes nothing. The data register is plain storage; nothing is transferred from it. Reads are combinational from the stored state, and writes take effect on the rising clock edge.

Top module: `cfg_cmd_ctrl`

## Requirements
- R1: After reset, the data, control and status registers all read as 0, and the power-down, restart and access-error outputs are low.
- R2: With the enabled identity, a write to offset 0xA0 stores all 32 bits, and a read of 0xA0 returns them unchanged.
- R3: A write to offset 0xA4 stores the written word with bits 31, 19 and 18 cleared, and every other bit kept.
- R4: Every write to offset 0xA4 sets status bit 0 (done), whatever the command word is.
- R5: If the written word, with bits 19:18 cleared, equals 0xC0800000, then `pwrdn_req` is high for exactly the one cycle after the write edge, `restart_req` stays low, and the status reads 1.
- R6: If the written word, with bits 19:18 cleared, equals 0xC0900000, then `restart_req` is high for exactly the one cycle after the write edge, `pwrdn_req` stays low, and the status reads 1.
- R7: Any other control word raises neither request line and leaves the status at 3 (done plus error in bit 1).
- R8: The command compare ignores bits 19:18 but includes bit 31. So 0xC09C0000 is a restart command, and 0x40800000 is an error.
- R9: A write to offset 0xA8 stores only bits 1:0 of the written word into the status.
- R10: When `board_id` differs from 0x190, an access to 0xA0, 0xA4 or 0xA8 drives `acc_err` high in the same cycle. A read returns 0, a write leaves all three registers unchanged, and neither request line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| board_id | input | 12 | Board identity strap |
| req | input | 1 | Access request this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of a read request |
| acc_err | output | 1 | Access to the register window while the identity is not enabled |
| pwrdn_req | output | 1 | One-cycle power-down request |
| restart_req | output | 1 | One-cycle restart request |

## Verification
The control register is driven with four kinds of word:
- both exact command codes;
- the restart code with the two ignored bits set, which shows that the compare masks those bits;
- the power-down code without its top bit, which shows that bit 31 still takes part in the compare;
- unrelated patterns, which must give the error status and no pulse.

Status writes with all-ones and mixed upper bits show that only the low two bits are stored. Accesses made under a foreign identity, followed by reads under the enabled identity, show that the earlier writes left no trace. A per-cycle model checks every pulse and read, so a pulse that lasts two cycles or arrives one cycle late is caught.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;
  localparam int WORD_W    = 32;
  localparam int STAT_W    = 2;
  localparam int STRIP_LO  = 18;
  localparam int STRIP_HI  = 19;
  localparam int START_BIT = 31;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STAT_W-1:0] stat_t;

  localparam word_t PWRDN_WORD   = 32'hC080_0000;
  localparam word_t RESTART_WORD = 32'hC090_0000;

  typedef enum logic [1:0] {
    KIND_PWRDN   = 2'd0,
    KIND_RESTART = 2'd1,
    KIND_UNKNOWN = 2'd2
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_DATA = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_STAT = 2'd3
  } reg_sel_e;

  // Clear the two ignored bits before the command compare.
  function automatic word_t strip_ctrl(word_t v);
    word_t r;
    r = v;
    for (int b = STRIP_LO; b <= STRIP_HI; b++) r[b] = 1'b0;
    return r;
  endfunction

  // Drop the start bit once the command has been decoded.
  function automatic word_t retire_start(word_t v);
    word_t r;
    r = v;
    r[START_BIT] = 1'b0;
    return r;
  endfunction

  function automatic cmd_kind_e classify(word_t stripped);
    if (stripped == PWRDN_WORD)        return KIND_PWRDN;
    else if (stripped == RESTART_WORD) return KIND_RESTART;
    else                               return KIND_UNKNOWN;
  endfunction

  // Bit 0 is done; bit 1 is error.
  function automatic stat_t status_for(cmd_kind_e k);
    return {k == KIND_UNKNOWN, 1'b1};
  endfunction
endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
  import cfg_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 12,
  parameter logic [ID_W-1:0]   ENABLED_ID = 12'h190,
  parameter logic [ADDR_W-1:0] OFF_DATA   = 12'hA0,
  parameter logic [ADDR_W-1:0] OFF_CTRL   = 12'hA4,
  parameter logic [ADDR_W-1:0] OFF_STAT   = 12'hA8
) (
  input  logic [ID_W-1:0]   board_id,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  output logic              wr_data,
  output logic              wr_ctrl,
  output logic              wr_stat,
  output reg_sel_e          rd_sel,
  output logic              acc_err
);
  localparam int NREG = 3;
  localparam logic [ADDR_W-1:0] OFFS [NREG] = '{OFF_DATA, OFF_CTRL, OFF_STAT};

  logic [NREG-1:0] hit;
  logic            in_window;
  logic            enabled;
  logic            live;

  for (genvar i = 0; i < NREG; i++) begin : g_hit
    assign hit[i] = (addr == OFFS[i]);
  end

  assign in_window = |hit;
  assign enabled   = (board_id == ENABLED_ID);
  assign live      = req && enabled;
  assign acc_err   = req && in_window && !enabled;

  assign wr_data = live && we && hit[0];
  assign wr_ctrl = live && we && hit[1];
  assign wr_stat = live && we && hit[2];

  always_comb begin
    rd_sel = SEL_NONE;
    if (live && !we) begin
      if (hit[0])      rd_sel = SEL_DATA;
      else if (hit[1]) rd_sel = SEL_CTRL;
      else if (hit[2]) rd_sel = SEL_STAT;
    end
  end
endmodule

// File: rtl/cfg_data_reg.sv
module cfg_data_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (wr) q <= wdata;
  end
endmodule

// File: rtl/cfg_cmd_exec.sv
module cfg_cmd_exec
  import cfg_cmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  logic  wr_stat,
  input  word_t wdata,
  output word_t ctrl_q,
  output stat_t stat_q,
  output logic  pwrdn_q,
  output logic  restart_q
);
  word_t     stripped;
  cmd_kind_e kind;

  assign stripped = strip_ctrl(wdata);
  assign kind     = classify(stripped);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      stat_q    <= '0;
      pwrdn_q   <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      pwrdn_q   <= 1'b0;
      restart_q <= 1'b0;
      if (wr_ctrl) begin
        ctrl_q    <= retire_start(stripped);
        stat_q    <= status_for(kind);
        pwrdn_q   <= (kind == KIND_PWRDN);
        restart_q <= (kind == KIND_RESTART);
      end else if (wr_stat) begin
        stat_q <= wdata[STAT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import cfg_cmd_pkg::*;
(
  input  reg_sel_e sel,
  input  word_t    data_q,
  input  word_t    ctrl_q,
  input  stat_t    stat_q,
  output word_t    rdata
);
  always_comb begin
    unique case (sel)
      SEL_DATA: rdata = data_q;
      SEL_CTRL: rdata = ctrl_q;
      SEL_STAT: rdata = word_t'(stat_q);
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_cmd_ctrl.sv
module cfg_cmd_ctrl
  import cfg_cmd_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 12,
  parameter logic [ID_W-1:0]   ENABLED_ID = 12'h190,
  parameter logic [ADDR_W-1:0] OFF_DATA   = 12'hA0,
  parameter logic [ADDR_W-1:0] OFF_CTRL   = 12'hA4,
  parameter logic [ADDR_W-1:0] OFF_STAT   = 12'hA8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   board_id,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              acc_err,
  output logic              pwrdn_req,
  output logic              restart_req
);
  // Named internal events, also observed by the bound checker.
  logic     wr_data_ev;
  logic     wr_ctrl_ev;
  logic     wr_stat_ev;
  reg_sel_e rd_sel;
  word_t    data_q;
  word_t    ctrl_q;
  stat_t    stat_q;

  cfg_addr_decode #(
    .ADDR_W(ADDR_W), .ID_W(ID_W), .ENABLED_ID(ENABLED_ID),
    .OFF_DATA(OFF_DATA), .OFF_CTRL(OFF_CTRL), .OFF_STAT(OFF_STAT)
  ) u_dec (
    .board_id(board_id), .req(req), .we(we), .addr(addr),
    .wr_data(wr_data_ev), .wr_ctrl(wr_ctrl_ev), .wr_stat(wr_stat_ev),
    .rd_sel(rd_sel), .acc_err(acc_err)
  );

  cfg_data_reg #(.W(WORD_W)) u_data (
    .clk(clk), .rst_n(rst_n), .wr(wr_data_ev), .wdata(wdata), .q(data_q)
  );

  cfg_cmd_exec u_exec (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl_ev), .wr_stat(wr_stat_ev),
    .wdata(wdata), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .pwrdn_q(pwrdn_req), .restart_q(restart_req)
  );

  cfg_read_mux u_rmux (
    .sel(rd_sel), .data_q(data_q), .ctrl_q(ctrl_q), .stat_q(stat_q),
    .rdata(rdata)
  );
endmodule

// File: rtl/cfg_cmd_ctrl_chk.sv
module cfg_cmd_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int ID_W   = 12,
  parameter logic [ID_W-1:0]   ENABLED_ID = 12'h190,
  parameter logic [ADDR_W-1:0] OFF_DATA   = 12'hA0,
  parameter logic [ADDR_W-1:0] OFF_CTRL   = 12'hA4,
  parameter logic [ADDR_W-1:0] OFF_STAT   = 12'hA8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ID_W-1:0]   board_id,
  input logic              req,
  input logic              we,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       rdata,
  input logic              acc_err,
  input logic              pwrdn_req,
  input logic              restart_req,
  input logic [31:0]       ctrl_q,
  input logic [1:0]        stat_q
);
  logic in_win, ok_id, ctl_wr, st_wr;
  logic [31:0] cmp_word;

  assign in_win   = (addr == OFF_DATA) || (addr == OFF_CTRL) || (addr == OFF_STAT);
  assign ok_id    = (board_id == ENABLED_ID);
  assign ctl_wr   = req && we && ok_id && (addr == OFF_CTRL);
  assign st_wr    = req && we && ok_id && (addr == OFF_STAT);
  assign cmp_word = wdata & 32'hFFF3_FFFF;

  assert_pulses_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwrdn_req, restart_req}));

  assert_ctrl_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> ctrl_q == ($past(wdata) & 32'h7FF3_FFFF));

  assert_done_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> stat_q[0]);

  assert_pwrdn_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cmp_word == 32'hC080_0000) |=> pwrdn_req);

  assert_restart_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cmp_word == 32'hC090_0000) |=> restart_req);

  assert_unknown_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && cmp_word != 32'hC080_0000 && cmp_word != 32'hC090_0000)
      |=> (stat_q == 2'b11 && !pwrdn_req && !restart_req));

  assert_status_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_wr |=> stat_q == $past(wdata[1:0]));

  assert_foreign_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && in_win && !ok_id) |-> (acc_err && rdata == 32'h0));

  assert_foreign_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && we && !ok_id) |=> ($stable(ctrl_q) && $stable(stat_q) && !pwrdn_req && !restart_req));
endmodule

bind cfg_cmd_ctrl cfg_cmd_ctrl_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .ENABLED_ID(ENABLED_ID),
  .OFF_DATA(OFF_DATA), .OFF_CTRL(OFF_CTRL), .OFF_STAT(OFF_STAT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .board_id(board_id), .req(req), .we(we),
  .addr(addr), .wdata(wdata), .rdata(rdata), .acc_err(acc_err),
  .pwrdn_req(pwrdn_req), .restart_req(restart_req),
  .ctrl_q(ctrl_q), .stat_q(stat_q)
);

// File: tb/tb_cfg_cmd_ctrl.sv
module tb_cfg_cmd_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] board_id = 12'h190;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        acc_err, pwrdn_req, restart_req;

  int checks = 0;
  int errs = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  cfg_cmd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .board_id(board_id), .req(req), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .acc_err(acc_err),
    .pwrdn_req(pwrdn_req), .restart_req(restart_req)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h at %0t", rq, act, exp, $time);
    end
  endtask

  // Behavioural reference model.
  logic [31:0] m_data = '0, m_ctrl = '0;
  logic [1:0]  m_stat = '0;
  logic        m_pd = 1'b0, m_rs = 1'b0;
  wire  [31:0] m_cmd = {wdata[31:20], 2'b00, wdata[17:0]};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_data <= '0; m_ctrl <= '0; m_stat <= '0; m_pd <= 1'b0; m_rs <= 1'b0;
    end else begin
      m_pd <= 1'b0; m_rs <= 1'b0;
      if (req && we && board_id == 12'h190) begin
        if (addr == 12'hA0) m_data <= wdata;
        else if (addr == 12'hA4) begin
          m_ctrl <= {1'b0, m_cmd[30:0]};
          if (m_cmd == 32'hC080_0000)      begin m_pd <= 1'b1; m_stat <= 2'd1; end
          else if (m_cmd == 32'hC090_0000) begin m_rs <= 1'b1; m_stat <= 2'd1; end
          else m_stat <= 2'd3;
        end else if (addr == 12'hA8) m_stat <= wdata[1:0];
      end
    end
  end

  function automatic logic [31:0] m_read();
    if (!(req && !we && board_id == 12'h190)) return 32'h0;
    case (addr)
      12'hA0:  return m_data;
      12'hA4:  return m_ctrl;
      12'hA8:  return {30'h0, m_stat};
      default: return 32'h0;
    endcase
  endfunction

  // Per-cycle comparison against the model.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && !finished) begin
        check("R5 pwrdn per-cycle", {31'h0, pwrdn_req}, {31'h0, m_pd});
        check("R6 restart per-cycle", {31'h0, restart_req}, {31'h0, m_rs});
        check("R10 acc_err per-cycle", {31'h0, acc_err},
              {31'h0, req && (addr == 12'hA0 || addr == 12'hA4 || addr == 12'hA8)
                      && board_id != 12'h190});
        check("R2 rdata per-cycle", rdata, m_read());
      end
    end
  end

  // Write; returns the request outputs seen in the cycle after the write edge.
  task automatic wr(input logic [11:0] a, input logic [31:0] d,
                    output logic pd, output logic rs);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    pd = pwrdn_req; rs = restart_req;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input string rq, input logic [11:0] a,
                    input logic [31:0] exp, input logic exp_err);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #2;
    check(rq, rdata, exp);
    check(rq, {31'h0, acc_err}, {31'h0, exp_err});
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #400000;
    errs++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    finish_run();
  end

  initial begin
    logic pd, rs;
    repeat (3) @(negedge clk);
    check("R1 pwrdn in reset", {31'h0, pwrdn_req}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 restart after reset", {31'h0, restart_req}, 32'h0);
    rd("R1 data", 12'hA0, 32'h0, 1'b0);
    rd("R1 ctrl", 12'hA4, 32'h0, 1'b0);
    rd("R1 stat", 12'hA8, 32'h0, 1'b0);

    wr(12'hA0, 32'hDEAD_BEEF, pd, rs);
    rd("R2 data", 12'hA0, 32'hDEAD_BEEF, 1'b0);
    wr(12'hA0, 32'hFFFF_FFFF, pd, rs);
    rd("R2 data ones", 12'hA0, 32'hFFFF_FFFF, 1'b0);

    wr(12'hA4, 32'h1234_5678, pd, rs);
    check("R7 no pwrdn", {31'h0, pd}, 32'h0);
    check("R7 no restart", {31'h0, rs}, 32'h0);
    rd("R3 ctrl masked", 12'hA4, 32'h1230_5678, 1'b0);
    rd("R7 stat error", 12'hA8, 32'h3, 1'b0);

    wr(12'hA8, 32'hFFFF_FFFC, pd, rs);
    rd("R9 stat low bits zero", 12'hA8, 32'h0, 1'b0);
    wr(12'hA8, 32'h0000_0005, pd, rs);
    rd("R9 stat low bits one", 12'hA8, 32'h1, 1'b0);

    wr(12'hA4, 32'hC080_0000, pd, rs);
    check("R5 pwrdn pulse", {31'h0, pd}, 32'h1);
    check("R5 no restart", {31'h0, rs}, 32'h0);
    @(negedge clk);
    check("R5 pulse one cycle", {31'h0, pwrdn_req}, 32'h0);
    rd("R3 start cleared", 12'hA4, 32'h4080_0000, 1'b0);
    rd("R4 done only", 12'hA8, 32'h1, 1'b0);

    wr(12'hA4, 32'hC09C_0000, pd, rs);
    check("R8 R6 restart pulse", {31'h0, rs}, 32'h1);
    check("R6 no pwrdn", {31'h0, pd}, 32'h0);
    @(negedge clk);
    check("R6 pulse one cycle", {31'h0, restart_req}, 32'h0);
    rd("R3 ctrl restart", 12'hA4, 32'h4090_0000, 1'b0);
    rd("R6 stat", 12'hA8, 32'h1, 1'b0);

    wr(12'hA4, 32'h4080_0000, pd, rs);
    check("R8 no pulse without bit31", {31'h0, pd | rs}, 32'h0);
    rd("R8 stat error", 12'hA8, 32'h3, 1'b0);

    wr(12'hA8, 32'h0, pd, rs);
    wr(12'hA4, 32'hC080_0001, pd, rs);
    check("R7 near code no pulse", {31'h0, pd | rs}, 32'h0);
    rd("R4 R7 stat after clear", 12'hA8, 32'h3, 1'b0);
    rd("R3 ctrl near code", 12'hA4, 32'h4080_0001, 1'b0);

    board_id = 12'h178;
    rd("R10 foreign read data", 12'hA0, 32'h0, 1'b1);
    wr(12'hA0, 32'h0000_1111, pd, rs);
    wr(12'hA4, 32'hC080_0000, pd, rs);
    check("R10 no pulse foreign", {31'h0, pd | rs}, 32'h0);
    wr(12'hA8, 32'h0, pd, rs);
    rd("R10 foreign read stat", 12'hA8, 32'h0, 1'b1);
    board_id = 12'h190;
    rd("R10 data kept", 12'hA0, 32'hFFFF_FFFF, 1'b0);
    rd("R10 ctrl kept", 12'hA4, 32'h4080_0001, 1'b0);
    rd("R10 stat kept", 12'hA8, 32'h3, 1'b0);
    rd("R10 other offset no err", 12'h040, 32'h0, 1'b0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule